// File: doc/BRIEF.md
# Ethernet PHY Autonegotiation Bring-Up Sequencer

This block brings an Ethernet PHY from an unknown state to a finished autonegotiation. It does this through register accesses on a management port. A start pulse launches a fixed sequence:

1. A software reset of the PHY, then polling until that reset ends.
2. Silencing of every PHY interrupt source.
3. Reading the PHY's ability bits and turning them into an advertisement word.
4. Restarting autonegotiation, then polling its status.

If the partner reports a remote fault during that wait, the block restarts negotiation with a forced configuration and keeps polling.

The block does not drive the serial management wires. Each read or write is handed to a separate management master over a request/acknowledge handshake, with one access in flight at a time. The spacing between polls is counted in ticks of an external slow strobe, so the same logic serves real half-second intervals on silicon and a few ticks in simulation. At the end, four registered flags report the outcome. They stay put until the next start pulse.

Top module: `phy_aneg_seq`

## Requirements
- R1: After synchronous reset, `mgmt_req`, `done`, `failed`, `reset_timeout` and `aneg_timeout` are all 0.
- R2: The first access after an accepted start is a write of 0x8000 (only bit 15, the PHY reset bit, set) to control address 0.
- R3: After the reset write, the control register is read repeatedly. Before each read there is an idle wait of at least `POLL_TICKS` tick pulses. Polling stops as soon as bit 15 reads 0. If `RST_POLLS` reads all show bit 15 set, `reset_timeout` and `done` rise and no further access is issued.
- R4: Once the reset bit has cleared, the next access writes 0xFFFF to the interrupt-mask address `MASK_ADDR`.
- R5: Status address 1 is then read once, and address 4 is written with an advertisement word. Bit 0 of that word is always 1. Status bits 15, 14, 13, 12 and 11 are copied to advertisement bits 9, 8, 7, 6 and 5 respectively. All other bits are 0.
- R6: Right after the advertisement write, control address 0 is written with 0x1200 (bit 12, negotiation enable, and bit 9, restart).
- R7: Status address 1 is then polled, with at least `POLL_TICKS` ticks before each read. A read with bit 5 (complete) set and bit 4 (remote fault) clear ends the sequence with `done` high and every error flag low.
- R8: If `AN_POLLS` such reads pass without success, `done` rises. `aneg_timeout` is set when bit 5 was clear in the last read.
- R9: A non-final poll that shows bit 4 set is followed by a control write of 0x3300 (enable, restart, speed bit 13, duplex bit 8), then polling resumes. No such write follows the final poll. `failed` is set when bit 4 is set in the final poll.
- R10: `mgmt_req` with its address, direction and write data stays stable until the cycle where `mgmt_ack` is high, and drops in the next cycle.
- R11: The result flags hold their value until the next start pulse, which clears them. A start pulse while a sequence runs has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches the sequence when idle |
| tick | input | 1 | Poll-interval strobe, one pulse per time unit |
| mgmt_req | output | 1 | Access request to the management master |
| mgmt_we | output | 1 | 1 for write, 0 for read |
| mgmt_addr | output | ADDR_W | PHY register address |
| mgmt_wdata | output | DATA_W | Write data |
| mgmt_ack | input | 1 | One-cycle completion from the management master |
| mgmt_rdata | input | DATA_W | Read data, valid while `mgmt_ack` is high |
| done | output | 1 | Sequence ended (success or error) |
| failed | output | 1 | Remote fault present on the last completion poll |
| reset_timeout | output | 1 | PHY reset never finished |
| aneg_timeout | output | 1 | Negotiation never completed |

## Verification
The hardest situations to reach are at the end of the negotiation wait. One is a remote fault that persists through the final permitted poll, both with and without the complete bit. The other is a fault that appears and then clears. Both must show exactly one restart write per non-final faulty poll and none after the last. The bench places a behavioural PHY on the handshake that acknowledges with latency. This model reports the control reset bit and the fault and complete bits as functions of how many reads of each register it has served. That lets a directed test fix the exact poll on which each condition appears or vanishes. The bench then counts the restart writes in its write log.

// File: rtl/phy_aneg_pkg.sv
package phy_aneg_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RST_WR,
    ST_RST_GAP,
    ST_RST_RD,
    ST_MASK_WR,
    ST_CAP_RD,
    ST_ADV_WR,
    ST_AN_WR,
    ST_AN_GAP,
    ST_AN_RD,
    ST_RF_WR
  } seq_state_t;

  // control register bit positions
  localparam int CTL_RESET_BIT   = 15;
  localparam int CTL_SPEED_BIT   = 13;
  localparam int CTL_AN_EN_BIT   = 12;
  localparam int CTL_RESTART_BIT = 9;
  localparam int CTL_DUPLEX_BIT  = 8;

  // status register bit positions
  localparam int STS_DONE_BIT    = 5;
  localparam int STS_RFAULT_BIT  = 4;
  localparam int STS_CAP_TOP     = 15;

  // advertisement layout
  localparam int ADV_CAP_TOP     = 9;
  localparam int ADV_SEL_BIT     = 0;
  localparam int NUM_CAPS        = 5;

endpackage

// File: rtl/mgmt_req_port.sv
module mgmt_req_port #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic              issue_we,
  input  logic [ADDR_W-1:0] issue_addr,
  input  logic [DATA_W-1:0] issue_data,
  input  logic              ack,
  output logic              req,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              xfer_done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      req   <= 1'b0;
      we    <= 1'b0;
      addr  <= '0;
      wdata <= '0;
    end else if (req && ack) begin
      req <= 1'b0;
    end else if (issue && !req) begin
      req   <= 1'b1;
      we    <= issue_we;
      addr  <= issue_addr;
      wdata <= issue_data;
    end
  end

  assign xfer_done = req && ack;

endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int INTERVAL = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic expired
);

  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q != CW'(INTERVAL))) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == CW'(INTERVAL));

endmodule

// File: rtl/adv_builder.sv
module adv_builder
  import phy_aneg_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] status_word,
  output logic [DATA_W-1:0] adv_word
);

  logic [DATA_W-1:0] caps;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    if (i <= ADV_CAP_TOP && i > ADV_CAP_TOP - NUM_CAPS) begin : g_cap
      assign caps[i] = status_word[STS_CAP_TOP - (ADV_CAP_TOP - i)];
    end else if (i == ADV_SEL_BIT) begin : g_sel
      assign caps[i] = 1'b1;
    end else begin : g_zero
      assign caps[i] = 1'b0;
    end
  end

  assign adv_word = caps;

endmodule

// File: rtl/phy_aneg_seq.sv
module phy_aneg_seq
  import phy_aneg_pkg::*;
#(
  parameter int                ADDR_W     = 5,
  parameter int                DATA_W     = 16,
  parameter int                POLL_TICKS = 500,
  parameter int                RST_POLLS  = 6,
  parameter int                AN_POLLS   = 20,
  parameter logic [ADDR_W-1:0] CTL_ADDR   = 0,
  parameter logic [ADDR_W-1:0] STS_ADDR   = 1,
  parameter logic [ADDR_W-1:0] ADV_ADDR   = 4,
  parameter logic [ADDR_W-1:0] MASK_ADDR  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              tick,
  output logic              mgmt_req,
  output logic              mgmt_we,
  output logic [ADDR_W-1:0] mgmt_addr,
  output logic [DATA_W-1:0] mgmt_wdata,
  input  logic              mgmt_ack,
  input  logic [DATA_W-1:0] mgmt_rdata,
  output logic              done,
  output logic              failed,
  output logic              reset_timeout,
  output logic              aneg_timeout
);

  localparam int RPW = $clog2(RST_POLLS + 1);
  localparam int APW = $clog2(AN_POLLS + 1);

  localparam logic [DATA_W-1:0] W_RESET = DATA_W'(1) << CTL_RESET_BIT;
  localparam logic [DATA_W-1:0] W_ANEG  = (DATA_W'(1) << CTL_AN_EN_BIT)
                                        | (DATA_W'(1) << CTL_RESTART_BIT);
  localparam logic [DATA_W-1:0] W_FORCE = W_ANEG
                                        | (DATA_W'(1) << CTL_SPEED_BIT)
                                        | (DATA_W'(1) << CTL_DUPLEX_BIT);
  localparam logic [DATA_W-1:0] W_MASK  = '1;

  seq_state_t        state_q;
  logic              issued_q;
  logic [RPW-1:0]    rst_poll_q;
  logic [APW-1:0]    an_poll_q;
  logic [DATA_W-1:0] cap_q;
  logic              done_q, failed_q, rto_q, ato_q;

  logic              want, issue, iss_we, xfer_done, gap_run, gap_expired;
  logic [ADDR_W-1:0] iss_addr;
  logic [DATA_W-1:0] iss_data, adv_word;

  adv_builder #(.DATA_W(DATA_W)) u_adv (
    .status_word (cap_q),
    .adv_word    (adv_word)
  );

  assign gap_run = (state_q == ST_RST_GAP) || (state_q == ST_AN_GAP);

  interval_timer #(.INTERVAL(POLL_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (gap_run),
    .tick    (tick),
    .expired (gap_expired)
  );

  // request decode per state
  always_comb begin
    want     = 1'b1;
    iss_we   = 1'b0;
    iss_addr = CTL_ADDR;
    iss_data = '0;
    unique case (state_q)
      ST_RST_WR:  begin iss_we = 1'b1; iss_data = W_RESET; end
      ST_RST_RD:  begin iss_addr = CTL_ADDR; end
      ST_MASK_WR: begin iss_we = 1'b1; iss_addr = MASK_ADDR; iss_data = W_MASK; end
      ST_CAP_RD:  begin iss_addr = STS_ADDR; end
      ST_ADV_WR:  begin iss_we = 1'b1; iss_addr = ADV_ADDR; iss_data = adv_word; end
      ST_AN_WR:   begin iss_we = 1'b1; iss_data = W_ANEG; end
      ST_AN_RD:   begin iss_addr = STS_ADDR; end
      ST_RF_WR:   begin iss_we = 1'b1; iss_data = W_FORCE; end
      default:    begin want = 1'b0; end
    endcase
  end

  assign issue = want && !issued_q && !mgmt_req;

  mgmt_req_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .issue      (issue),
    .issue_we   (iss_we),
    .issue_addr (iss_addr),
    .issue_data (iss_data),
    .ack        (mgmt_ack),
    .req        (mgmt_req),
    .we         (mgmt_we),
    .addr       (mgmt_addr),
    .wdata      (mgmt_wdata),
    .xfer_done  (xfer_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      issued_q   <= 1'b0;
      rst_poll_q <= '0;
      an_poll_q  <= '0;
      cap_q      <= '0;
      done_q     <= 1'b0;
      failed_q   <= 1'b0;
      rto_q      <= 1'b0;
      ato_q      <= 1'b0;
    end else begin
      if (issue)     issued_q <= 1'b1;
      if (xfer_done) issued_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            done_q     <= 1'b0;
            failed_q   <= 1'b0;
            rto_q      <= 1'b0;
            ato_q      <= 1'b0;
            rst_poll_q <= '0;
            an_poll_q  <= '0;
            state_q    <= ST_RST_WR;
          end
        end
        ST_RST_WR:  if (xfer_done)   state_q <= ST_RST_GAP;
        ST_RST_GAP: if (gap_expired) state_q <= ST_RST_RD;
        ST_RST_RD: begin
          if (xfer_done) begin
            if (!mgmt_rdata[CTL_RESET_BIT]) begin
              state_q <= ST_MASK_WR;
            end else if (rst_poll_q == RPW'(RST_POLLS - 1)) begin
              rto_q   <= 1'b1;
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              rst_poll_q <= rst_poll_q + 1'b1;
              state_q    <= ST_RST_GAP;
            end
          end
        end
        ST_MASK_WR: if (xfer_done) state_q <= ST_CAP_RD;
        ST_CAP_RD: begin
          if (xfer_done) begin
            cap_q   <= mgmt_rdata;
            state_q <= ST_ADV_WR;
          end
        end
        ST_ADV_WR:  if (xfer_done)   state_q <= ST_AN_WR;
        ST_AN_WR:   if (xfer_done)   state_q <= ST_AN_GAP;
        ST_AN_GAP:  if (gap_expired) state_q <= ST_AN_RD;
        ST_AN_RD: begin
          if (xfer_done) begin
            if (mgmt_rdata[STS_DONE_BIT] && !mgmt_rdata[STS_RFAULT_BIT]) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else if (an_poll_q == APW'(AN_POLLS - 1)) begin
              done_q   <= 1'b1;
              ato_q    <= !mgmt_rdata[STS_DONE_BIT];
              failed_q <= mgmt_rdata[STS_RFAULT_BIT];
              state_q  <= ST_IDLE;
            end else begin
              an_poll_q <= an_poll_q + 1'b1;
              state_q   <= mgmt_rdata[STS_RFAULT_BIT] ? ST_RF_WR : ST_AN_GAP;
            end
          end
        end
        ST_RF_WR: if (xfer_done) state_q <= ST_AN_GAP;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign done          = done_q;
  assign failed        = failed_q;
  assign reset_timeout = rto_q;
  assign aneg_timeout  = ato_q;

endmodule

// File: rtl/phy_aneg_seq_chk.sv
module phy_aneg_seq_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mgmt_req,
  input logic              mgmt_we,
  input logic [ADDR_W-1:0] mgmt_addr,
  input logic [DATA_W-1:0] mgmt_wdata,
  input logic              mgmt_ack,
  input logic              done,
  input logic              failed,
  input logic              reset_timeout,
  input logic              aneg_timeout
);

  p_req_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req && !mgmt_ack) |=> (mgmt_req && $stable(mgmt_we)
                                 && $stable(mgmt_addr) && $stable(mgmt_wdata)));

  p_req_drop_r10: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req && mgmt_ack) |=> !mgmt_req);

  p_done_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_rto_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (reset_timeout && !start) |=> reset_timeout);

  p_quiet_done_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> !mgmt_req);

  p_ctl_word_r6: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req && mgmt_we && mgmt_addr == '0) |->
      (mgmt_wdata == 16'h8000 || mgmt_wdata == 16'h1200 || mgmt_wdata == 16'h3300));

  p_adv_sel_r5: assert property (@(posedge clk) disable iff (rst)
    (mgmt_req && mgmt_we && mgmt_addr == ADDR_W'(4)) |-> mgmt_wdata[0]);

  p_flags_done_r8: assert property (@(posedge clk) disable iff (rst)
    (aneg_timeout || failed || reset_timeout) |-> done);

endmodule

bind phy_aneg_seq phy_aneg_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .start         (start),
  .mgmt_req      (mgmt_req),
  .mgmt_we       (mgmt_we),
  .mgmt_addr     (mgmt_addr),
  .mgmt_wdata    (mgmt_wdata),
  .mgmt_ack      (mgmt_ack),
  .done          (done),
  .failed        (failed),
  .reset_timeout (reset_timeout),
  .aneg_timeout  (aneg_timeout)
);

// File: tb/phy_aneg_seq_test.sv
module phy_aneg_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int POLL       = 3;
  localparam int ACK_LAT    = 2;
  localparam int WD_LIMIT   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        tick = 1'b0;
  logic        mgmt_req, mgmt_we, mgmt_ack;
  logic [4:0]  mgmt_addr;
  logic [15:0] mgmt_wdata, mgmt_rdata;
  logic        done, failed, reset_timeout, aneg_timeout;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural PHY configuration and log
  logic [15:0] cfg_caps;
  int cfg_busy, cfg_cmp, cfg_rf_first, cfg_rf_last;
  int n_wr, n_ctl_rd, n_st_rd;
  logic [4:0]  wr_addr [64];
  logic [15:0] wr_data [64];
  int tick_total = 0;
  int last_ack_tick, min_gap;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_aneg_seq #(.POLL_TICKS(POLL)) uut (
    .clk (clk), .rst (rst), .start (start), .tick (tick),
    .mgmt_req (mgmt_req), .mgmt_we (mgmt_we), .mgmt_addr (mgmt_addr),
    .mgmt_wdata (mgmt_wdata), .mgmt_ack (mgmt_ack), .mgmt_rdata (mgmt_rdata),
    .done (done), .failed (failed), .reset_timeout (reset_timeout),
    .aneg_timeout (aneg_timeout)
  );

  // tick strobe every other cycle
  initial begin
    forever begin
      @(negedge clk);
      tick = ~tick;
      if (tick) tick_total++;
    end
  end

  // management responder
  initial begin
    int wait_cnt;
    int g;
    wait_cnt = 0;
    mgmt_ack = 1'b0;
    mgmt_rdata = '0;
    forever begin
      @(negedge clk);
      if (mgmt_ack) begin
        mgmt_ack = 1'b0;
      end else if (mgmt_req) begin
        if (wait_cnt < ACK_LAT) begin
          wait_cnt++;
        end else begin
          wait_cnt = 0;
          g = tick_total - last_ack_tick;
          if (mgmt_we) begin
            if (n_wr < 64) begin
              wr_addr[n_wr] = mgmt_addr;
              wr_data[n_wr] = mgmt_wdata;
            end
            n_wr++;
          end else if (mgmt_addr == 5'd0) begin
            mgmt_rdata = (n_ctl_rd < cfg_busy) ? 16'h8000 : 16'h0000;
            if (g < min_gap) min_gap = g;
            n_ctl_rd++;
          end else begin
            mgmt_rdata = cfg_caps;
            if (n_st_rd >= cfg_cmp) mgmt_rdata[5] = 1'b1;
            if (n_st_rd >= cfg_rf_first && n_st_rd <= cfg_rf_last) mgmt_rdata[4] = 1'b1;
            if (n_st_rd >= 1 && g < min_gap) min_gap = g;
            n_st_rd++;
          end
          last_ack_tick = tick_total;
          mgmt_ack = 1'b1;
        end
      end
    end
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      report();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int count_wr(input logic [15:0] d);
    int n = 0;
    for (int i = 0; i < n_wr && i < 64; i++) if (wr_data[i] == d) n++;
    return n;
  endfunction

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic run_seq(input logic [15:0] caps, input int busy, input int cmp,
                         input int rff, input int rfl, input bit poke);
    cfg_caps = caps; cfg_busy = busy; cfg_cmp = cmp;
    cfg_rf_first = rff; cfg_rf_last = rfl;
    n_wr = 0; n_ctl_rd = 0; n_st_rd = 0;
    min_gap = 1 << 30; last_ack_tick = tick_total;
    pulse_start();
    chk("R11 flags cleared by start",
        {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'd0);
    if (poke) begin
      repeat (4) @(negedge clk);
      pulse_start();
    end
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_prefix(input logic [15:0] adv);
    chk("R2 first write addr", {27'd0, wr_addr[0]}, 32'd0);
    chk("R2 first write data", {16'd0, wr_data[0]}, 32'h8000);
    chk("R4 mask write addr", {27'd0, wr_addr[1]}, 32'd19);
    chk("R4 mask write data", {16'd0, wr_data[1]}, 32'hFFFF);
    chk("R5 adv write addr", {27'd0, wr_addr[2]}, 32'd4);
    chk("R5 adv word", {16'd0, wr_data[2]}, {16'd0, adv});
    chk("R6 restart write", {11'd0, wr_addr[3], wr_data[3]}, {11'd0, 5'd0, 16'h1200});
  endtask

  task automatic t_normal();
    run_seq(16'hF800, 1, 3, 1000, 0, 1'b1);
    check_prefix(16'h03E1);
    chk("R3 ctl reads", n_ctl_rd, 2);
    chk("R3 poll spacing", min_gap >= POLL, 1);
    chk("R7 status reads", n_st_rd, 4);
    chk("R7 success flags", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1000);
    chk("R11 start ignored while busy", count_wr(16'h8000), 1);
    chk("R7 write count", n_wr, 4);
    chk("R10 req low after done", mgmt_req, 0);
  endtask

  task automatic t_caps();
    run_seq(16'h6800, 0, 1, 1000, 0, 1'b0);
    chk("R5 adv partial", {16'd0, wr_data[2]}, 32'h01A1);
    chk("R3 single ctl read", n_ctl_rd, 1);
    run_seq(16'h0000, 0, 1, 1000, 0, 1'b0);
    chk("R5 adv empty", {16'd0, wr_data[2]}, 32'h0001);
    run_seq(16'h9000, 0, 1, 1000, 0, 1'b0);
    chk("R5 adv t4 and 10fd", {16'd0, wr_data[2]}, 32'h0241);
  endtask

  task automatic t_reset_timeout();
    run_seq(16'hF800, 100, 1, 1000, 0, 1'b0);
    chk("R3 reset polls", n_ctl_rd, 6);
    chk("R3 no later access", n_wr + n_st_rd, 1);
    chk("R3 timeout flags", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1010);
    chk("R3 poll spacing", min_gap >= POLL, 1);
  endtask

  task automatic t_aneg_timeout();
    run_seq(16'hF800, 0, 1000, 1000, 0, 1'b0);
    chk("R8 status reads", n_st_rd, 21);
    chk("R8 flags", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1001);
    chk("R9 no restart without fault", count_wr(16'h3300), 0);
    repeat (20) @(negedge clk);
    chk("R11 flags held", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1001);
  endtask

  task automatic t_rf_transient();
    run_seq(16'hF800, 0, 2, 1, 2, 1'b0);
    chk("R9 restart count", count_wr(16'h3300), 2);
    chk("R9 restart addr", {27'd0, wr_addr[4]}, 32'd0);
    chk("R9 status reads", n_st_rd, 4);
    chk("R9 recovered flags", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1000);
  endtask

  task automatic t_rf_persistent();
    run_seq(16'hF800, 0, 1000, 1, 1000, 1'b0);
    chk("R9 restarts not on final poll", count_wr(16'h3300), 19);
    chk("R9 fault and timeout", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1101);
    run_seq(16'hF800, 0, 1, 1, 1000, 1'b0);
    chk("R9 fault with complete", {28'd0, done, failed, reset_timeout, aneg_timeout}, 32'b1100);
    chk("R8 poll limit", n_st_rd, 21);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset state",
        {27'd0, mgmt_req, done, failed, reset_timeout, aneg_timeout}, 32'd0);
    t_normal();
    t_caps();
    t_reset_timeout();
    t_aneg_timeout();
    t_rf_transient();
    t_rf_persistent();
    finished = 1'b1;
    report();
  end

endmodule